// File: doc/BRIEF.md
# Display Modeline Validator and Clamper

This block takes a requested video mode, given as eight 16-bit numbers, and returns a corrected mode that fits the widths of the timing registers. The horizontal group holds display end, sync start, sync end and total, all in pixels. The vertical group holds the same four values in lines. A generation select picks between the tighter display limits of the oldest parts and the wider limits of newer ones.

A request is presented with `req_valid` and is taken in on a clock edge where `req_ready` is also high. The block then applies eight rule groups, one per clock cycle and always in the same order. Each group sees the values that the groups before it have already corrected. When the last group has run, the corrected mode is copied to the output registers and `done` pulses for one cycle. The outputs then hold their values until the next request has been processed.

Top module: `modeline_clamp`

## Requirements
- R1: Out of reset `req_ready` is high. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low from the edge after acceptance until `done` is asserted.
- R2: `done` goes high at the ninth rising edge after the accepting edge and stays high for exactly one cycle.
- R3: All four horizontal values are rounded down to a multiple of 8 by clearing bits [2:0].
- R4: The horizontal field caps are 4072 for display end, 4080 for sync start, 4088 for sync end and 4128 for total. They are applied after rounding.
- R5: Horizontal display end is held at 640 or above. Its maximum is 2048 when `gen_new`=1 and 1920 when `gen_new`=0.
- R6: Horizontal total is raised to at least display end + 80. After that it is lowered to at most display end + 1016.
- R7: Horizontal sync end is lowered to total − 8 or below. Sync start is then raised to display end + 8 or above. Sync end is then lowered to at most sync start + 248.
- R8: The vertical field caps are 2045 for display end, 2046 for sync start, 2047 for sync end and 2049 for total. No rounding is applied to the vertical values.
- R9: Vertical display end is held at 480 or above. Its maximum is 1536 when `gen_new`=1 and 1440 when `gen_new`=0.
- R10: Vertical total is raised to display end + 3, then lowered to display end + 255. Sync end is then lowered to total − 1 or below. Sync start is raised to display end + 1 or above. Sync end is finally limited to sync start + 15.
- R11: Reset clears all outputs to 0 and `done` to 0. The outputs change only on the edge that raises `done`, and they hold their values afterwards.
- R12: `gen_new` is sampled only on the accepting edge. Changing it later has no effect on that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| gen_new | input | 1 | 1 selects the newer display limits, 0 the oldest |
| in_h_disp | input | 16 | Requested horizontal display end |
| in_h_sync_start | input | 16 | Requested horizontal sync start |
| in_h_sync_end | input | 16 | Requested horizontal sync end |
| in_h_total | input | 16 | Requested horizontal total |
| in_v_disp | input | 16 | Requested vertical display end |
| in_v_sync_start | input | 16 | Requested vertical sync start |
| in_v_sync_end | input | 16 | Requested vertical sync end |
| in_v_total | input | 16 | Requested vertical total |
| done | output | 1 | One-cycle pulse when corrected values are loaded |
| out_h_disp | output | 16 | Corrected horizontal display end |
| out_h_sync_start | output | 16 | Corrected horizontal sync start |
| out_h_sync_end | output | 16 | Corrected horizontal sync end |
| out_h_total | output | 16 | Corrected horizontal total |
| out_v_disp | output | 16 | Corrected vertical display end |
| out_v_sync_start | output | 16 | Corrected vertical sync start |
| out_v_sync_end | output | 16 | Corrected vertical sync end |
| out_v_total | output | 16 | Corrected vertical total |

## Verification
The checker cannot see which generation was latched, so it bounds display end by the wider of the two limits. The exact generation-dependent maximum is left to the bench. The properties on the results take for granted that every input word is a legal request, which holds for any 16-bit value. Any input combination is therefore allowed, and the stimulus mixes values from the whole 16-bit range with values near each limit. The handshake properties assume `req_valid` may stay high at any time. The bench raises it only while `req_ready` is high and drops it on the cycle after acceptance.

// File: rtl/modeline_pkg.sv
package modeline_pkg;
  localparam int MW = 16;

  typedef struct packed {
    logic [MW-1:0] disp;
    logic [MW-1:0] ss;
    logic [MW-1:0] se;
    logic [MW-1:0] tot;
  } axis_t;
endpackage

// File: rtl/modeline_axis_rules.sv
// One rule group of one axis, selected by grp; purely combinational.
module modeline_axis_rules
  import modeline_pkg::*;
#(
  parameter int GRID_BITS    = 3,
  parameter int CAP_DISP     = 4072,
  parameter int CAP_SS       = 4080,
  parameter int CAP_SE       = 4088,
  parameter int CAP_TOT      = 4128,
  parameter int DISP_MIN     = 640,
  parameter int DISP_MAX_NEW = 2048,
  parameter int DISP_MAX_OLD = 1920,
  parameter int TOT_MIN_GAP  = 80,
  parameter int TOT_MAX_GAP  = 1016,
  parameter int SYNC_LEN_MAX = 248
) (
  input  axis_t      cur,
  input  logic [1:0] grp,
  input  logic       gen_new,
  output axis_t      nxt
);
  localparam int            SYNC_GAP  = 1 << GRID_BITS;
  localparam logic [MW-1:0] GRID_MASK = ~(MW'((1 << GRID_BITS) - 1));

  axis_t         t;
  logic [MW-1:0] dmax;

  assign dmax = gen_new ? MW'(DISP_MAX_NEW) : MW'(DISP_MAX_OLD);

  always_comb begin
    t = cur;
    unique case (grp)
      2'd0: begin
        t.disp = t.disp & GRID_MASK;
        t.ss   = t.ss   & GRID_MASK;
        t.se   = t.se   & GRID_MASK;
        t.tot  = t.tot  & GRID_MASK;
        if (t.disp > MW'(CAP_DISP)) t.disp = MW'(CAP_DISP);
        if (t.ss   > MW'(CAP_SS))   t.ss   = MW'(CAP_SS);
        if (t.se   > MW'(CAP_SE))   t.se   = MW'(CAP_SE);
        if (t.tot  > MW'(CAP_TOT))  t.tot  = MW'(CAP_TOT);
      end
      2'd1: begin
        if (t.disp < MW'(DISP_MIN)) t.disp = MW'(DISP_MIN);
        if (t.disp > dmax)          t.disp = dmax;
      end
      2'd2: begin
        if (t.tot < t.disp + MW'(TOT_MIN_GAP)) t.tot = t.disp + MW'(TOT_MIN_GAP);
        if (t.tot > t.disp + MW'(TOT_MAX_GAP)) t.tot = t.disp + MW'(TOT_MAX_GAP);
      end
      default: begin
        if (t.se > t.tot - MW'(SYNC_GAP))     t.se = t.tot - MW'(SYNC_GAP);
        if (t.ss < t.disp + MW'(SYNC_GAP))    t.ss = t.disp + MW'(SYNC_GAP);
        if (t.se > t.ss + MW'(SYNC_LEN_MAX))  t.se = t.ss + MW'(SYNC_LEN_MAX);
      end
    endcase
    nxt = t;
  end
endmodule

// File: rtl/modeline_seq.sv
// Steps through the rule groups after a start and flags the final one.
module modeline_seq #(
  parameter int GROUPS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  output logic                      busy,
  output logic [$clog2(GROUPS)-1:0] step,
  output logic                      finish
);
  localparam int            SW   = $clog2(GROUPS);
  localparam logic [SW-1:0] LAST = SW'(GROUPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= '0;
      finish <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (step == LAST) begin
          busy   <= 1'b0;
          finish <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modeline_clamp.sv
module modeline_clamp
  import modeline_pkg::*;
#(
  parameter int H_FIELD_BITS   = 9,
  parameter int V_FIELD_BITS   = 11,
  parameter int H_DISP_MIN     = 640,
  parameter int H_DISP_MAX_NEW = 2048,
  parameter int H_DISP_MAX_OLD = 1920,
  parameter int V_DISP_MIN     = 480,
  parameter int V_DISP_MAX_NEW = 1536,
  parameter int V_DISP_MAX_OLD = 1440
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          gen_new,
  input  logic [MW-1:0] in_h_disp,
  input  logic [MW-1:0] in_h_sync_start,
  input  logic [MW-1:0] in_h_sync_end,
  input  logic [MW-1:0] in_h_total,
  input  logic [MW-1:0] in_v_disp,
  input  logic [MW-1:0] in_v_sync_start,
  input  logic [MW-1:0] in_v_sync_end,
  input  logic [MW-1:0] in_v_total,
  output logic          done,
  output logic [MW-1:0] out_h_disp,
  output logic [MW-1:0] out_h_sync_start,
  output logic [MW-1:0] out_h_sync_end,
  output logic [MW-1:0] out_h_total,
  output logic [MW-1:0] out_v_disp,
  output logic [MW-1:0] out_v_sync_start,
  output logic [MW-1:0] out_v_sync_end,
  output logic [MW-1:0] out_v_total
);
  localparam int GRID_BITS   = 3;
  localparam int H_LIM       = (1 << H_FIELD_BITS) - 1;
  localparam int V_LIM       = (1 << V_FIELD_BITS) - 1;
  localparam int GW          = 2;
  localparam int RULE_GROUPS = 2 * (1 << GW);
  localparam int SW          = $clog2(RULE_GROUPS);

  axis_t         work_h, work_v, h_nxt, v_nxt, res_h, res_v;
  logic          gen_q, busy, finish, accept;
  logic [SW-1:0] step;

  assign req_ready = !busy && !finish;
  assign accept    = req_valid && req_ready;

  modeline_seq #(.GROUPS(RULE_GROUPS)) u_seq (
    .clk(clk), .rst(rst), .start(accept),
    .busy(busy), .step(step), .finish(finish)
  );

  modeline_axis_rules #(
    .GRID_BITS(GRID_BITS),
    .CAP_DISP((H_LIM - 2) << GRID_BITS), .CAP_SS((H_LIM - 1) << GRID_BITS),
    .CAP_SE(H_LIM << GRID_BITS),         .CAP_TOT((H_LIM + 5) << GRID_BITS),
    .DISP_MIN(H_DISP_MIN), .DISP_MAX_NEW(H_DISP_MAX_NEW), .DISP_MAX_OLD(H_DISP_MAX_OLD),
    .TOT_MIN_GAP(80), .TOT_MAX_GAP(127 << GRID_BITS), .SYNC_LEN_MAX(31 << GRID_BITS)
  ) u_h_rules (
    .cur(work_h), .grp(step[GW-1:0]), .gen_new(gen_q), .nxt(h_nxt)
  );

  modeline_axis_rules #(
    .GRID_BITS(0),
    .CAP_DISP(V_LIM - 2), .CAP_SS(V_LIM - 1), .CAP_SE(V_LIM), .CAP_TOT(V_LIM + 2),
    .DISP_MIN(V_DISP_MIN), .DISP_MAX_NEW(V_DISP_MAX_NEW), .DISP_MAX_OLD(V_DISP_MAX_OLD),
    .TOT_MIN_GAP(3), .TOT_MAX_GAP(255), .SYNC_LEN_MAX(15)
  ) u_v_rules (
    .cur(work_v), .grp(step[GW-1:0]), .gen_new(gen_q), .nxt(v_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      work_h <= '0;
      work_v <= '0;
      res_h  <= '0;
      res_v  <= '0;
      gen_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        work_h <= '{disp: in_h_disp, ss: in_h_sync_start, se: in_h_sync_end, tot: in_h_total};
        work_v <= '{disp: in_v_disp, ss: in_v_sync_start, se: in_v_sync_end, tot: in_v_total};
        gen_q  <= gen_new;
      end else if (busy) begin
        if (!step[SW-1]) work_h <= h_nxt;
        else             work_v <= v_nxt;
      end
      if (finish) begin
        res_h <= work_h;
        res_v <= work_v;
      end
    end
  end

  assign out_h_disp       = res_h.disp;
  assign out_h_sync_start = res_h.ss;
  assign out_h_sync_end   = res_h.se;
  assign out_h_total      = res_h.tot;
  assign out_v_disp       = res_v.disp;
  assign out_v_sync_start = res_v.ss;
  assign out_v_sync_end   = res_v.se;
  assign out_v_total      = res_v.tot;
endmodule

// File: rtl/modeline_clamp_checker.sv
module modeline_clamp_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic [15:0] out_h_disp,
  input logic [15:0] out_h_sync_start,
  input logic [15:0] out_h_sync_end,
  input logic [15:0] out_h_total,
  input logic [15:0] out_v_disp,
  input logic [15:0] out_v_sync_start,
  input logic [15:0] out_v_sync_end,
  input logic [15:0] out_v_total
);
  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_h_disp) && $stable(out_h_sync_start) &&
               $stable(out_h_sync_end) && $stable(out_h_total) &&
               $stable(out_v_disp) && $stable(out_v_sync_start) &&
               $stable(out_v_sync_end) && $stable(out_v_total)));

  a_r3_grid_aligned: assert property (@(posedge clk) disable iff (rst)
    done |-> ((out_h_disp[2:0] | out_h_sync_start[2:0] |
               out_h_sync_end[2:0] | out_h_total[2:0]) == 3'd0));

  a_r5_hdisp_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_h_disp >= 16'd640 && out_h_disp <= 16'd2048));

  a_r6_htotal_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_h_total >= out_h_disp + 16'd80 &&
              out_h_total <= out_h_disp + 16'd1016));

  a_r7_hsync_place: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_h_sync_start >= out_h_disp + 16'd8 &&
              out_h_sync_end <= out_h_sync_start + 16'd248 &&
              out_h_sync_end <= out_h_total - 16'd8));

  a_r9_vdisp_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_v_disp >= 16'd480 && out_v_disp <= 16'd1536));

  a_r10_vertical_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_v_total >= out_v_disp + 16'd3 &&
              out_v_total <= out_v_disp + 16'd255 &&
              out_v_sync_start >= out_v_disp + 16'd1 &&
              out_v_sync_end <= out_v_sync_start + 16'd15 &&
              out_v_sync_end <= out_v_total - 16'd1));
endmodule

bind modeline_clamp modeline_clamp_checker u_chk (.*);

// File: tb/modeline_clamp_test.sv
module modeline_clamp_test;
  typedef logic [15:0] mode_t [8];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        gen_new = 1'b1;
  logic [15:0] in_h_disp = '0, in_h_sync_start = '0, in_h_sync_end = '0, in_h_total = '0;
  logic [15:0] in_v_disp = '0, in_v_sync_start = '0, in_v_sync_end = '0, in_v_total = '0;
  logic        done;
  logic [15:0] out_h_disp, out_h_sync_start, out_h_sync_end, out_h_total;
  logic [15:0] out_v_disp, out_v_sync_start, out_v_sync_end, out_v_total;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1357_2468;

  always #4 clk = ~clk;

  modeline_clamp uut (.*);

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic mode_t model(input mode_t r, input bit g);
    mode_t m = r;
    logic [15:0] dmx;
    for (int i = 0; i < 4; i++) m[i] = m[i] & 16'hFFF8;          // R3
    if (m[0] > 16'd4072) m[0] = 16'd4072;                         // R4
    if (m[1] > 16'd4080) m[1] = 16'd4080;
    if (m[2] > 16'd4088) m[2] = 16'd4088;
    if (m[3] > 16'd4128) m[3] = 16'd4128;
    dmx = g ? 16'd2048 : 16'd1920;                                // R5
    if (m[0] < 16'd640) m[0] = 16'd640;
    if (m[0] > dmx) m[0] = dmx;
    if (m[3] < m[0] + 16'd80) m[3] = m[0] + 16'd80;               // R6
    if (m[3] > m[0] + 16'd1016) m[3] = m[0] + 16'd1016;
    if (m[2] > m[3] - 16'd8) m[2] = m[3] - 16'd8;                 // R7
    if (m[1] < m[0] + 16'd8) m[1] = m[0] + 16'd8;
    if (m[2] > m[1] + 16'd248) m[2] = m[1] + 16'd248;
    if (m[4] > 16'd2045) m[4] = 16'd2045;                         // R8
    if (m[5] > 16'd2046) m[5] = 16'd2046;
    if (m[6] > 16'd2047) m[6] = 16'd2047;
    if (m[7] > 16'd2049) m[7] = 16'd2049;
    dmx = g ? 16'd1536 : 16'd1440;                                // R9
    if (m[4] < 16'd480) m[4] = 16'd480;
    if (m[4] > dmx) m[4] = dmx;
    if (m[7] < m[4] + 16'd3) m[7] = m[4] + 16'd3;                 // R10
    if (m[7] > m[4] + 16'd255) m[7] = m[4] + 16'd255;
    if (m[6] > m[7] - 16'd1) m[6] = m[7] - 16'd1;
    if (m[5] < m[4] + 16'd1) m[5] = m[4] + 16'd1;
    if (m[6] > m[5] + 16'd15) m[6] = m[5] + 16'd15;
    return m;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input mode_t exp, input string tag);
    mode_t act;
    string tg;
    act = '{out_h_disp, out_h_sync_start, out_h_sync_end, out_h_total,
            out_v_disp, out_v_sync_start, out_v_sync_end, out_v_total};
    for (int i = 0; i < 8; i++) begin
      if (tag != "") tg = tag;
      else begin
        case (i)
          0: tg = "R5";
          1, 2: tg = "R7";
          3: tg = "R6";
          4: tg = "R9";
          default: tg = "R10";
        endcase
      end
      chk(tg, $sformatf("field %0d", i), {16'd0, act[i]}, {16'd0, exp[i]});
    end
  endtask

  // Drive a request at a negedge; flip gen after acceptance when asked (R12).
  task automatic run(input mode_t r, input bit g, input bit flip, input string tag);
    int lat;
    while (!req_ready) @(negedge clk);
    {in_h_disp, in_h_sync_start, in_h_sync_end, in_h_total} = {r[0], r[1], r[2], r[3]};
    {in_v_disp, in_v_sync_start, in_v_sync_end, in_v_total} = {r[4], r[5], r[6], r[7]};
    gen_new   = g;
    req_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    req_valid = 1'b0;
    chk("R1", "ready after accept", {31'd0, req_ready}, 32'd0);
    if (flip) gen_new = ~g;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R2", "latency", lat, 32'd10);
    compare(model(r, g), tag);
    @(negedge clk);
    chk("R2", "done width", {31'd0, done}, 32'd0);
    chk("R1", "ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  function automatic logic [15:0] pick(input logic [31:0] rv, input int span);
    if (rv[31:28] == 4'hF) return 16'hFFFF;
    return 16'(rv[27:8] % span);
  endfunction

  initial begin
    mode_t r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "reset done", {31'd0, done}, 32'd0);
    chk("R11", "reset h_disp", {16'd0, out_h_disp}, 32'd0);
    chk("R11", "reset v_total", {16'd0, out_v_total}, 32'd0);
    chk("R1", "reset ready", {31'd0, req_ready}, 32'd1);

    // R3: low bits cleared on a mode already inside every limit
    r = '{16'd1027, 16'd1100, 16'd1205, 16'd1343, 16'd768, 16'd771, 16'd777, 16'd806};
    run(r, 1'b1, 1'b0, "R3");
    // R4 / R8: all-ones request exposes sync start caps (4080 / 2046)
    r = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    run(r, 1'b1, 1'b0, "R4");
    run(r, 1'b0, 1'b0, "R8");
    // R5 / R9: below minimum and between the two generation maxima
    r = '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
    run(r, 1'b0, 1'b0, "");
    r = '{16'd2000, 16'd2100, 16'd2200, 16'd2400, 16'd1500, 16'd1510, 16'd1515, 16'd1600};
    run(r, 1'b0, 1'b0, "");
    run(r, 1'b1, 1'b0, "");
    // R12: select flipped after acceptance must not matter
    r = '{16'd2048, 16'd2100, 16'd2200, 16'd2400, 16'd1536, 16'd1540, 16'd1545, 16'd1600};
    run(r, 1'b1, 1'b1, "R12");
    run(r, 1'b0, 1'b1, "R12");
    // R7 / R10: long sync pulses get trimmed
    r = '{16'd800, 16'd808, 16'd1800, 16'd1800, 16'd600, 16'd601, 16'd700, 16'd700};
    run(r, 1'b1, 1'b0, "");

    // R11: outputs hold across idle cycles
    repeat (6) @(negedge clk);
    compare(model(r, 1'b1), "R11");

    // sweep of both generations over pseudo-random requests
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < 8; i++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        r[i] = pick(seed, (i < 4) ? 4400 : 2200);
      end
      run(r, n[0], 1'b0, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule